// File: doc/BRIEF.md
# Two-Section Decade Counter with Preset-to-Nine

This block is a four-bit counter made of two sections that run on their own. The low section divides by two and drives `q_o[0]`. The high section divides by five and drives `q_o[3:1]`. Each section has its own count input and advances when that input falls. Both count inputs are asynchronous levels. They pass through a synchroniser into the system clock domain, and a falling-edge detector there produces a one-cycle advance pulse for each section. No derived clocks are created.

Two gated overrides take precedence over counting. The clear acts only when both of its pins are high. The preset acts only when both of its pins are high, and it loads nine; the preset wins over the clear. A link-mode input stands in for external wiring between the sections:
- In decimal mode, the low bit's falling edge drives the high section, so the output counts in 8421 BCD.
- In bi-quinary mode, the high section's top bit drives the low section, so `q_o[0]` becomes a symmetric divide-by-ten square wave.
- In separate mode, each section counts only from its own input.

Top module: `split_decade_counter`

## Requirements
- R1: A section advances only on a falling edge of its count source. A rising edge has no effect. For an external count input, the output changes on the third rising clock edge after the input falls: two synchroniser stages, then the counter register.
- R2: With `link_mode_i` = 2'b00, each falling edge on `cnt_a_i` inverts `q_o[0]`.
- R3: With `link_mode_i` = 2'b00, each falling edge on `cnt_b_i` steps `q_o[3:1]` (`q_o[1]` least significant) through 0, 1, 2, 3, 4 and back to 0. The high section never holds a value above 4.
- R4: Either of the following sets `q_o` to 4'b0000: `rst_n` low, or `clr_a_i` and `clr_b_i` both high with the preset inactive. Either clear pin high on its own changes nothing.
- R5: When `nine_a_i` and `nine_b_i` are both high, `q_o` becomes 4'b1001 (`q_o[3]`=1, `q_o[0]`=1), whatever the clear pins are. Either preset pin on its own changes nothing.
- R6: Falling edges that arrive while an override is active are discarded, and after release the output keeps its override value. This includes a fall of `q_o[0]` or `q_o[3]` caused by the override itself in a linked mode.
- R7: With `link_mode_i` = 2'b01, falling edges on `cnt_a_i` step `q_o` through 8421 BCD 0 to 9 and then wrap to 0. In this mode `cnt_b_i` is ignored.
- R8: With `link_mode_i` = 2'b10, falling edges on `cnt_b_i` produce a `q_o[0]` that stays low for five counts and high for five counts. In this mode `cnt_a_i` is ignored.
- R9: With `link_mode_i` = 2'b11, the sections count independently, exactly as in separate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a_i | input | 1 | Count input of the divide-by-two section (asynchronous level) |
| cnt_b_i | input | 1 | Count input of the divide-by-five section (asynchronous level) |
| clr_a_i | input | 1 | Clear gate, first pin |
| clr_b_i | input | 1 | Clear gate, second pin |
| nine_a_i | input | 1 | Preset-to-nine gate, first pin |
| nine_b_i | input | 1 | Preset-to-nine gate, second pin |
| link_mode_i | input | 2 | 00 separate, 01 decimal (low bit feeds high section), 10 bi-quinary (top bit feeds low section), 11 separate |
| q_o | output | 4 | Counter value, high section in bits 3:1, low section in bit 0 |

## Verification
The assertions assume the following of the inputs:
- Count inputs hold each level for several clock cycles, so every fall yields exactly one advance pulse.
- `link_mode_i` changes only while the clear is held, so switching the cascade source cannot produce a false edge.
- Override pins are sampled as plain synchronous levels.

The stimulus keeps to these assumptions. It drives every input on the falling clock edge and holds each count level for at least four cycles. Every random mode change is wrapped inside a clear that lasts several cycles. Count-input noise during an override is released only after the synchroniser has settled.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [1:0] {
        LINK_NONE  = 2'b00,
        LINK_DEC   = 2'b01,
        LINK_BIQ   = 2'b10,
        LINK_SPARE = 2'b11
    } link_e;

endpackage

// File: rtl/sdc_fall_detect.sv
module sdc_fall_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    input  logic int_i,
    input  logic use_int_i,
    output logic fall_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } fd_state_t;

    fd_state_t st_d, st_q;
    logic [SYNC_STAGES-1:0] sync_shift;
    logic sel;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            assign sync_shift = ext_i;
        end else begin : g_many
            assign sync_shift = {st_q.sync[SYNC_STAGES-2:0], ext_i};
        end
    endgenerate

    always_comb begin
        sel       = use_int_i ? int_i : st_q.sync[SYNC_STAGES-1];
        st_d      = st_q;
        st_d.sync = sync_shift;
        st_d.prev = sel;
        fall_o    = st_q.prev & ~sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: a fall yields a single-cycle pulse, never two in a row
    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/sdc_div2_stage.sv
module sdc_div2_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic clr_i,
    input  logic set_i,
    output logic bit_o
);

    typedef struct packed {
        logic bit_v;
    } d2_state_t;

    d2_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.bit_v = 1'b1;
        end else if (clr_i) begin
            st_d.bit_v = 1'b0;
        end else if (step_i) begin
            st_d.bit_v = ~st_q.bit_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.bit_v;

    assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && !set_i) |=> (bit_o != $past(bit_o)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clr_i && !set_i) |=> $stable(bit_o));

endmodule

// File: rtl/sdc_mod_stage.sv
module sdc_mod_stage #(
    parameter int MOD = 5,
    parameter int W   = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         clr_i,
    input  logic         set_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] TOP_V = W'(MOD - 1);
    localparam logic [W:0]   MOD_V = (W + 1)'(MOD);

    typedef struct packed {
        logic [W-1:0] cnt;
    } md_state_t;

    md_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.cnt = TOP_V;
        end else if (clr_i) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            // top state and any unused code return to zero
            if (st_q.cnt >= TOP_V) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    assert_legal_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_o} < MOD_V));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && !set_i) |=>
        (cnt_o == (($past(cnt_o) == TOP_V) ? '0 : $past(cnt_o) + 1'b1)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clr_i && !set_i) |=> $stable(cnt_o));

endmodule

// File: rtl/split_decade_counter.sv
module split_decade_counter #(
    parameter int SYNC_STAGES = 2,
    parameter int HI_MOD      = 5,
    localparam int HI_W       = $clog2(HI_MOD),
    localparam int OUT_W      = HI_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_a_i,
    input  logic             cnt_b_i,
    input  logic             clr_a_i,
    input  logic             clr_b_i,
    input  logic             nine_a_i,
    input  logic             nine_b_i,
    input  logic [1:0]       link_mode_i,
    output logic [OUT_W-1:0] q_o
);

    localparam logic [OUT_W-1:0] PRESET_V = {HI_W'(HI_MOD - 1), 1'b1};

    typedef struct packed {
        logic ovr;
    } top_state_t;

    top_state_t st_d, st_q;

    sdc_pkg::link_e link;
    logic clr_now, set_now, ovr_now;
    logic use_int_lo, use_int_hi;
    logic fall_lo, fall_hi;
    logic step_lo, step_hi;
    logic lo_q;
    logic [HI_W-1:0] hi_q;

    always_comb begin
        link       = sdc_pkg::link_e'(link_mode_i);
        clr_now    = clr_a_i & clr_b_i;
        set_now    = nine_a_i & nine_b_i;
        ovr_now    = clr_now | set_now;
        use_int_lo = (link == sdc_pkg::LINK_BIQ);
        use_int_hi = (link == sdc_pkg::LINK_DEC);
        // edges seen during an override, or caused by its last cycle, are dropped
        step_lo    = fall_lo & ~ovr_now & ~st_q.ovr;
        step_hi    = fall_hi & ~ovr_now & ~st_q.ovr;
        st_d       = st_q;
        st_d.ovr   = ovr_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sdc_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_fd_lo (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_i     (cnt_a_i),
        .int_i     (hi_q[HI_W-1]),
        .use_int_i (use_int_lo),
        .fall_o    (fall_lo)
    );

    sdc_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_fd_hi (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_i     (cnt_b_i),
        .int_i     (lo_q),
        .use_int_i (use_int_hi),
        .fall_o    (fall_hi)
    );

    sdc_div2_stage u_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_lo),
        .clr_i  (clr_now),
        .set_i  (set_now),
        .bit_o  (lo_q)
    );

    sdc_mod_stage #(.MOD(HI_MOD), .W(HI_W)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_hi),
        .clr_i  (clr_now),
        .set_i  (set_now),
        .cnt_o  (hi_q)
    );

    assign q_o = {hi_q, lo_q};

    assert_preset_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_a_i && nine_b_i) |=> (q_o == PRESET_V));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a_i && clr_b_i && !(nine_a_i && nine_b_i)) |=> (q_o == '0));

    assert_release_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && !ovr_now) |=> $stable(q_o));

endmodule

// File: tb/tb_split_decade_counter.sv
module tb_split_decade_counter;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       cnt_a = 1'b0, cnt_b = 1'b0;
    logic       clr_a = 1'b0, clr_b = 1'b0;
    logic       nine_a = 1'b0, nine_b = 1'b0;
    logic [1:0] link = 2'b00;
    logic [3:0] q;

    split_decade_counter dut (
        .clk(clk), .rst_n(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
        .clr_a_i(clr_a), .clr_b_i(clr_b), .nine_a_i(nine_a), .nine_b_i(nine_b),
        .link_mode_i(link), .q_o(q)
    );

    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;
    logic       m0 = 1'b0;
    logic [2:0] m5 = 3'd0;
    logic [1:0] mode = 2'b00;

    function automatic logic [2:0] adv5(input logic [2:0] v);
        return (v >= 3'd4) ? 3'd0 : v + 3'd1;
    endfunction

    function automatic logic [3:0] exp_q();
        return {m5, m0};
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: q_o=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fall_a();
        logic old;
        cnt_a = 1'b1; settle(5);
        cnt_a = 1'b0; settle(5);
        if (mode != 2'b10) begin
            old = m0;
            m0  = ~m0;
            if (mode == 2'b01 && old) m5 = adv5(m5);
        end
    endtask

    task automatic fall_b();
        logic old3;
        cnt_b = 1'b1; settle(5);
        cnt_b = 1'b0; settle(5);
        if (mode != 2'b01) begin
            old3 = (m5 == 3'd4);
            m5   = adv5(m5);
            if (mode == 2'b10 && old3) m0 = ~m0;
        end
    endtask

    task automatic override(input bit do_clr, input bit do_set, input bit noise);
        clr_a = do_clr; clr_b = do_clr; nine_a = do_set; nine_b = do_set;
        settle(4);
        if (noise) begin
            cnt_a = 1'b1; cnt_b = 1'b1; settle(4);
            cnt_a = 1'b0; cnt_b = 1'b0; settle(5);
        end
        clr_a = 1'b0; clr_b = 1'b0; nine_a = 1'b0; nine_b = 1'b0;
        settle(4);
        if (do_set) begin m0 = 1'b1; m5 = 3'd4; end
        else if (do_clr) begin m0 = 1'b0; m5 = 3'd0; end
    endtask

    task automatic set_mode(input logic [1:0] m);
        clr_a = 1'b1; clr_b = 1'b1; settle(3);
        link = m; mode = m; settle(4);
        clr_a = 1'b0; clr_b = 1'b0; settle(4);
        m0 = 1'b0; m5 = 3'd0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        settle(3);
        check("R4 reset", q, 4'b0000);
        rst_n = 1'b1;
        settle(3);

        // R1 latency: change lands on third edge after the fall
        cnt_a = 1'b1; settle(6);
        check("R1 rise ignored", q, 4'b0000);
        @(negedge clk); cnt_a = 1'b0;
        settle(2);
        check("R1 not yet", q, 4'b0000);
        settle(1);
        check("R1 third edge", q, 4'b0001);
        m0 = 1'b1; settle(4);

        // R2 / R3 separate mode
        for (int i = 0; i < 3; i++) begin fall_a(); check("R2 toggle", q, exp_q()); end
        for (int i = 0; i < 7; i++) begin fall_b(); check("R3 step", q, exp_q()); end
        check("R3 wrap value", q[3:1], 3'd2);

        // R4 clear and single pins
        clr_a = 1'b1; settle(4); check("R4 single clear pin", q, exp_q()); clr_a = 1'b0;
        clr_b = 1'b1; fall_b(); check("R4 counts with one pin", q, exp_q()); clr_b = 1'b0;
        override(1'b1, 1'b0, 1'b0); check("R4 clear", q, 4'b0000);

        // R5 preset
        nine_a = 1'b1; settle(4); check("R5 single preset pin", q, 4'b0000); nine_a = 1'b0;
        override(1'b0, 1'b1, 1'b0); check("R5 nine", q, 4'b1001);
        fall_a(); check("R5 after nine", q, exp_q());
        override(1'b1, 1'b1, 1'b0); check("R5 wins over clear", q, 4'b1001);

        // R6 noise during override
        override(1'b1, 1'b0, 1'b1); check("R6 clear noise", q, 4'b0000);
        override(1'b0, 1'b1, 1'b1); check("R6 preset noise", q, 4'b1001);

        // R7 decimal mode
        set_mode(2'b01);
        for (int i = 1; i <= 12; i++) begin
            fall_a();
            check("R7 bcd", q, 4'(i % 10));
        end
        fall_b(); check("R7 cnt_b ignored", q, exp_q());
        override(1'b0, 1'b1, 1'b0); check("R7 nine", q, 4'b1001);
        fall_a(); check("R7 nine wraps", q, 4'b0000);
        override(1'b0, 1'b1, 1'b0);
        override(1'b1, 1'b0, 1'b0); check("R6 induced fall dropped", q, 4'b0000);

        // R8 bi-quinary mode
        set_mode(2'b10);
        for (int i = 1; i <= 20; i++) begin
            fall_b();
            check("R8 square wave", {3'b000, q[0]}, {3'b000, 1'((i / 5) % 2)});
        end
        fall_a(); check("R8 cnt_a ignored", q, exp_q());
        override(1'b0, 1'b1, 1'b0);
        override(1'b1, 1'b0, 1'b0); check("R6 induced q3 fall dropped", q, 4'b0000);

        // R9 spare code
        set_mode(2'b11);
        fall_a(); check("R9 low", q, exp_q());
        fall_b(); fall_b(); check("R9 high", q, exp_q());

        // random mix
        for (int i = 0; i < 300; i++) begin
            case ($urandom % 8)
                0, 1:    begin fall_a(); check("R2 random", q, exp_q()); end
                2, 3:    begin fall_b(); check("R3 random", q, exp_q()); end
                4:       begin override(1'b1, 1'($urandom % 2), 1'($urandom % 2)); check("R6 random", q, exp_q()); end
                5:       begin override(1'b0, 1'b1, 1'($urandom % 2)); check("R5 random", q, exp_q()); end
                6:       begin nine_b = 1'b1; clr_a = 1'b1; fall_a(); nine_b = 1'b0; clr_a = 1'b0; check("R4 random pin", q, exp_q()); end
                default: begin set_mode(2'($urandom % 4)); check("R9 random mode", q, 4'b0000); end
            endcase
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: q_o=%b expected completion", q);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule